// File: doc/BRIEF.md
# Audio Converter Power-Mode Sequencer

This block runs on the host side of an audio converter and walks it through its power states: supply bring-up, first wake with channel and DAC setup, sleep entry with a status handshake, and later re-wakes. It drives a generic register command port (address, write data, write/read select, a strobe held until a one-cycle done pulse, and returned read data). It waits whole milliseconds by counting cycles of a clock of known frequency. It also owns the enables for the frame-sync and bit clocks that the audio serial link needs. All registers sit on page 0, which the command port is assumed to have selected.

The system asks for a change with single-cycle wake or sleep request pulses and reports whether the supplies are good. The block answers with busy, active and error flags. Sleep is only complete once the converter reports through its status register that it has shut down. The first wake after power-up programs the channel-enable and DAC power registers. Later wakes skip that step because the converter keeps its register contents while asleep.

Top module: `codec_power_sequencer`

## Requirements
- R1: While reset is asserted and afterwards with `supply_ok` low, `cmd_valid`, `fsync_en`, `bclk_en`, `busy`, `active` and `error` are all 0.
- R2: After `supply_ok` rises, no command is issued for at least PWRUP_MS × CLK_PER_MS cycles. The block then rests in sleep with `busy` = 0 and `active` = 0.
- R3: The first wake after power-up writes address 2 with WAKE_VAL, then waits at least WAKE_MS ms. It then writes addresses 40 to 47 in ascending order with CHAN_ON_VAL, and then address 120 with DAC_ON_VAL.
- R4: The clock enables rise only when a wake sequence completes, and at that moment `active` rises. They never rise before the first wake.
- R5: Sleep entry writes address 2 with SLEEP_VAL and waits at least SLEEP_MS ms. It then reads address 122 (`cmd_write` = 0). If read bits [7:5] equal 3'b100, the clock enables drop and the block rests in sleep.
- R6: If the status bits differ from 3'b100, the block waits 1 ms and reads again, for at most STATUS_RETRIES re-reads. After that it sets `error`, keeps the clocks running and returns to active. `error` clears when the next sleep sequence starts.
- R7: A wake after a completed sleep (with no supply loss in between) writes only address 2 with WAKE_VAL. It then waits WAKE_MS ms and re-enables the clocks.
- R8: A wake or sleep request that arrives while a sequence is running, or before power-up completes, is held. It is serviced as soon as the block reaches the resting state it applies to.
- R9: A request for the mode the block is already resting in issues no command and leaves `busy` low.
- R10: When `supply_ok` falls, the clock enables and `active` go low on the next cycle. A later wake performs the full first-wake configuration again.
- R11: While `cmd_valid` is high and `cmd_done` has not arrived, `cmd_valid`, `cmd_write`, `cmd_addr` and `cmd_wdata` stay stable.
- R12: `busy` is 1 throughout the power-up wait and every wake or sleep sequence, and 0 while resting in sleep or active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_PER_MS cycles per millisecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Converter supplies are good |
| wake_req | input | 1 | Request pulse to enter active mode |
| sleep_req | input | 1 | Request pulse to enter sleep mode |
| cmd_valid | output | 1 | Command strobe, held until cmd_done |
| cmd_write | output | 1 | 1 = register write, 0 = register read |
| cmd_addr | output | 8 | Page-0 register address |
| cmd_wdata | output | 8 | Write data |
| cmd_done | input | 1 | One-cycle completion pulse from the command port |
| cmd_rdata | input | 8 | Read data, valid with cmd_done |
| fsync_en | output | 1 | Frame-sync clock enable |
| bclk_en | output | 1 | Bit clock enable |
| busy | output | 1 | A power-up wait or mode sequence is running |
| active | output | 1 | Resting in active mode |
| error | output | 1 | Shutdown status never confirmed on the last sleep attempt |

## Verification
The assertions assume that the command port raises `cmd_done` for exactly one cycle, and only while `cmd_valid` is high. They also assume that `cmd_rdata` is meaningful only in that cycle. The bench's port model answers every strobe after a fixed latency with a single done pulse, and it drives status only through `cmd_rdata`. Request pulses are one cycle wide and are applied at the falling edge. Supply loss is applied only at a falling edge, so the rules for held commands and for clock shutdown are never exercised with a half-applied change.

// File: rtl/codec_power_sequencer.sv
module codec_power_sequencer #(
  parameter int         CLK_PER_MS     = 100_000,
  parameter int         PWRUP_MS       = 1,
  parameter int         WAKE_MS        = 1,
  parameter int         SLEEP_MS       = 6,
  parameter int         STATUS_RETRIES = 3,
  parameter logic [7:0] WAKE_VAL       = 8'h00,
  parameter logic [7:0] SLEEP_VAL      = 8'h01,
  parameter logic [7:0] CHAN_ON_VAL    = 8'h80,
  parameter logic [7:0] DAC_ON_VAL     = 8'h0C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       wake_req,
  input  logic       sleep_req,
  output logic       cmd_valid,
  output logic       cmd_write,
  output logic [7:0] cmd_addr,
  output logic [7:0] cmd_wdata,
  input  logic       cmd_done,
  input  logic [7:0] cmd_rdata,
  output logic       fsync_en,
  output logic       bclk_en,
  output logic       busy,
  output logic       active,
  output logic       error
);

  localparam logic [7:0] ADDR_MODE    = 8'd2;
  localparam logic [7:0] ADDR_CH_BASE = 8'd40;
  localparam logic [7:0] ADDR_DAC     = 8'd120;
  localparam logic [7:0] ADDR_STATUS  = 8'd122;
  localparam int         N_CH         = 8;
  localparam int         CYC_W        = $clog2(CLK_PER_MS + 1);
  localparam int         MS_W         = $clog2(PWRUP_MS + WAKE_MS + SLEEP_MS + 2) + 1;
  localparam int         RT_W         = $clog2(STATUS_RETRIES + 1) + 1;
  localparam int         PW_CYC       = PWRUP_MS * CLK_PER_MS;
  localparam int         PW_W         = $clog2(PW_CYC + 1);

  typedef enum logic [3:0] {
    S_OFF, S_PWR_WAIT, S_SLEEP, S_WAKE_WR, S_WAKE_WAIT, S_CFG_WR,
    S_ACTIVE, S_SLP_WR, S_SLP_WAIT, S_STAT_RD, S_RETRY_WAIT
  } state_t;

  state_t            state;
  logic [CYC_W-1:0]  cyc;
  logic [MS_W-1:0]   ms, ms_tgt;
  logic [3:0]        cfg_idx;
  logic [RT_W-1:0]   retry;
  logic              wake_p, sleep_p, configured, clk_en;
  logic              waiting, wait_done, status_ok, cfg_last;

  assign waiting   = state inside {S_PWR_WAIT, S_WAKE_WAIT, S_SLP_WAIT, S_RETRY_WAIT};
  assign wait_done = waiting && (ms == ms_tgt);
  assign status_ok = (cmd_rdata & 8'hE0) == 8'h80;
  assign cfg_last  = cfg_idx == 4'(N_CH);

  always_comb begin
    case (state)
      S_PWR_WAIT:  ms_tgt = MS_W'(PWRUP_MS);
      S_WAKE_WAIT: ms_tgt = MS_W'(WAKE_MS);
      S_SLP_WAIT:  ms_tgt = MS_W'(SLEEP_MS);
      default:     ms_tgt = MS_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0;
      ms  <= '0;
    end else if (!waiting || wait_done || !supply_ok) begin
      cyc <= '0;
      ms  <= '0;
    end else if (cyc == CYC_W'(CLK_PER_MS - 1)) begin
      cyc <= '0;
      ms  <= ms + 1'b1;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_OFF;
      wake_p     <= 1'b0;
      sleep_p    <= 1'b0;
      configured <= 1'b0;
      clk_en     <= 1'b0;
      error      <= 1'b0;
      cfg_idx    <= '0;
      retry      <= '0;
    end else begin
      if (wake_req)  wake_p  <= 1'b1;
      if (sleep_req) sleep_p <= 1'b1;
      if (!supply_ok) begin
        state      <= S_OFF;
        configured <= 1'b0;
        clk_en     <= 1'b0;
        error      <= 1'b0;
        cfg_idx    <= '0;
        retry      <= '0;
      end else begin
        case (state)
          S_OFF:      state <= S_PWR_WAIT;
          S_PWR_WAIT: if (wait_done) state <= S_SLEEP;
          S_SLEEP: begin
            sleep_p <= 1'b0;
            if (wake_p) begin
              wake_p <= 1'b0;
              state  <= S_WAKE_WR;
            end
          end
          S_WAKE_WR:  if (cmd_done) state <= S_WAKE_WAIT;
          S_WAKE_WAIT:
            if (wait_done) begin
              if (configured) begin
                clk_en <= 1'b1;
                state  <= S_ACTIVE;
              end else begin
                cfg_idx <= '0;
                state   <= S_CFG_WR;
              end
            end
          S_CFG_WR:
            if (cmd_done) begin
              if (cfg_last) begin
                configured <= 1'b1;
                clk_en     <= 1'b1;
                state      <= S_ACTIVE;
              end else begin
                cfg_idx <= cfg_idx + 1'b1;
              end
            end
          S_ACTIVE: begin
            wake_p <= 1'b0;
            if (sleep_p) begin
              sleep_p <= 1'b0;
              error   <= 1'b0;
              retry   <= '0;
              state   <= S_SLP_WR;
            end
          end
          S_SLP_WR:     if (cmd_done) state <= S_SLP_WAIT;
          S_SLP_WAIT:   if (wait_done) state <= S_STAT_RD;
          S_RETRY_WAIT: if (wait_done) state <= S_STAT_RD;
          S_STAT_RD:
            if (cmd_done) begin
              if (status_ok) begin
                clk_en <= 1'b0;
                state  <= S_SLEEP;
              end else if (retry == RT_W'(STATUS_RETRIES)) begin
                error <= 1'b1;
                state <= S_ACTIVE;
              end else begin
                retry <= retry + 1'b1;
                state <= S_RETRY_WAIT;
              end
            end
          default: state <= S_OFF;
        endcase
      end
    end
  end

  assign cmd_valid = state inside {S_WAKE_WR, S_CFG_WR, S_SLP_WR, S_STAT_RD};
  assign cmd_write = cmd_valid && (state != S_STAT_RD);

  always_comb begin
    cmd_addr  = ADDR_MODE;
    cmd_wdata = 8'h00;
    case (state)
      S_WAKE_WR: cmd_wdata = WAKE_VAL;
      S_SLP_WR:  cmd_wdata = SLEEP_VAL;
      S_STAT_RD: cmd_addr  = ADDR_STATUS;
      S_CFG_WR: begin
        cmd_addr  = cfg_last ? ADDR_DAC : ADDR_CH_BASE + 8'(cfg_idx);
        cmd_wdata = cfg_last ? DAC_ON_VAL : CHAN_ON_VAL;
      end
      default: ;
    endcase
  end

  assign fsync_en = clk_en;
  assign bclk_en  = clk_en;
  assign active   = state == S_ACTIVE;
  assign busy     = !(state inside {S_OFF, S_SLEEP, S_ACTIVE});

  logic [PW_W-1:0] sup_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       sup_cnt <= '0;
    else if (!supply_ok)              sup_cnt <= '0;
    else if (sup_cnt != PW_W'(PW_CYC)) sup_cnt <= sup_cnt + 1'b1;
  end

  assert_no_early_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> sup_cnt == PW_W'(PW_CYC));

  assert_clk_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_en) |-> active && bclk_en);

  assert_clk_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync_en) |-> $past(!supply_ok) || $past(cmd_done && !cmd_write && status_ok));

  assert_error_keeps_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> fsync_en && active);

  assert_supply_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !fsync_en && !active);

  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done && supply_ok) |=>
      cmd_valid && $stable(cmd_write) && $stable(cmd_addr) && $stable(cmd_wdata));

endmodule

// File: tb/test_codec_power_sequencer.sv
`timescale 1ns/1ps
module test_codec_power_sequencer;
  localparam int MS = 10;
  localparam int RETRIES = 2;
  localparam logic [7:0] WV = 8'h00, SV = 8'h01, CV = 8'h80, DV = 8'h0C;

  logic clk = 0, rst_n = 0, supply_ok = 0, wake_req = 0, sleep_req = 0;
  logic cmd_valid, cmd_write, cmd_done, fsync_en, bclk_en, busy, active, error;
  logic [7:0] cmd_addr, cmd_wdata, cmd_rdata, status_val;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  codec_power_sequencer #(.CLK_PER_MS(MS), .PWRUP_MS(1), .WAKE_MS(1), .SLEEP_MS(6),
    .STATUS_RETRIES(RETRIES), .WAKE_VAL(WV), .SLEEP_VAL(SV), .CHAN_ON_VAL(CV),
    .DAC_ON_VAL(DV)) i_codec_power_sequencer (.*);

  // command port model: done after 3 cycles of strobe, logs every command
  int cyc = 0, lat = 0, seq_n = 0, viol = 0;
  logic [7:0] seq_addr [0:127];
  logic [7:0] seq_data [0:127];
  logic       seq_wr   [0:127];
  int         seq_cyc  [0:127];
  logic [7:0] held_addr, held_data;
  logic       pending = 0;

  assign cmd_rdata = status_val;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cmd_done) begin
      cmd_done <= 0; lat <= 0; pending <= 0;
    end else if (cmd_valid) begin
      if (pending && (cmd_addr != held_addr || cmd_wdata != held_data)) viol <= viol + 1;
      pending <= 1; held_addr <= cmd_addr; held_data <= cmd_wdata;
      if (lat == 2) begin
        cmd_done <= 1;
        seq_addr[seq_n] <= cmd_addr; seq_data[seq_n] <= cmd_wdata;
        seq_wr[seq_n] <= cmd_write; seq_cyc[seq_n] <= cyc;
        seq_n <= seq_n + 1;
      end else lat <= lat + 1;
    end else begin
      lat <= 0; pending <= 0;
    end
  end

  initial cmd_done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_wake();
    @(negedge clk) wake_req = 1; @(negedge clk) wake_req = 0;
  endtask
  task automatic pulse_sleep();
    @(negedge clk) sleep_req = 1; @(negedge clk) sleep_req = 0;
  endtask
  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check({cmd_valid, fsync_en, bclk_en, busy, active, error} == 0, "R1 outputs in reset",
          {cmd_valid, fsync_en, bclk_en, busy, active, error}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check({cmd_valid, fsync_en, busy, active, error} == 0, "R1 outputs supply low",
          {cmd_valid, fsync_en, busy, active, error}, 0);
  endtask

  task automatic t_powerup_first_wake();
    int base, n, gap;
    pulse_wake();                      // R8: held through power-up
    @(negedge clk) supply_ok = 1;
    n = 0;
    for (int i = 0; i < 100 && !cmd_valid; i++) begin
      @(negedge clk); n++;
      if (n == 3) check(busy == 1, "R12 busy during power-up wait", busy, 1);
    end
    check(n >= MS, "R2 no command before power-up wait", n, MS);
    base = seq_n;
    for (int i = 0; i < 3000 && !active; i++) @(negedge clk);
    check(active == 1 && busy == 0, "R8 held wake serviced after power-up", active, 1);
    check(seq_n - base == 10, "R3 first wake command count", seq_n - base, 10);
    check(seq_addr[base] == 2 && seq_data[base] == WV && seq_wr[base], "R3 wake write",
          seq_addr[base], 2);
    for (int k = 0; k < 8; k++)
      check(seq_addr[base+1+k] == 8'(40 + k) && seq_data[base+1+k] == CV && seq_wr[base+1+k],
            "R3 channel enable write", seq_addr[base+1+k], 40 + k);
    check(seq_addr[base+9] == 120 && seq_data[base+9] == DV, "R3 DAC power write",
          seq_addr[base+9], 120);
    gap = seq_cyc[base+1] - seq_cyc[base];
    check(gap >= MS, "R3 wake wait before configuration", gap, MS);
    check(fsync_en && bclk_en, "R4 clocks on after first wake", fsync_en, 1);
  endtask

  task automatic t_same_mode_active();
    int base = seq_n;
    pulse_wake();
    repeat (20) begin
      @(negedge clk);
      if (busy) check(0, "R9 wake while active raised busy", busy, 0);
    end
    check(seq_n == base && active, "R9 wake while active ignored", seq_n - base, 0);
  endtask

  task automatic t_sleep_ok();
    int base = seq_n, gap;
    status_val = 8'h9F;                // bits[7:5]=100, low bits set
    pulse_sleep();
    repeat (3) @(negedge clk);
    check(busy == 1 && fsync_en == 1, "R12 busy with clocks during sleep entry", busy, 1);
    wait_idle();
    check(seq_n - base == 2, "R5 sleep command count", seq_n - base, 2);
    check(seq_addr[base] == 2 && seq_data[base] == SV && seq_wr[base], "R5 sleep write",
          seq_data[base], SV);
    check(seq_addr[base+1] == 122 && !seq_wr[base+1], "R5 status read", seq_addr[base+1], 122);
    gap = seq_cyc[base+1] - seq_cyc[base];
    check(gap >= 6 * MS, "R5 sleep wait length", gap, 6 * MS);
    check(!fsync_en && !bclk_en && !active && !busy, "R5 clocks stopped in sleep", fsync_en, 0);
  endtask

  task automatic t_same_mode_sleep();
    int base = seq_n;
    pulse_sleep();
    repeat (20) begin
      @(negedge clk);
      if (busy || cmd_valid) check(0, "R9 sleep while asleep raised busy", busy, 0);
    end
    check(seq_n == base && !active, "R9 sleep while asleep ignored", seq_n - base, 0);
  endtask

  task automatic t_rewake();
    int base = seq_n;
    pulse_wake();
    repeat (3) @(negedge clk);
    check(!fsync_en, "R4 clocks stay off during wake wait", fsync_en, 0);
    wait_idle();
    check(seq_n - base == 1, "R7 re-wake single write", seq_n - base, 1);
    check(seq_addr[base] == 2 && seq_data[base] == WV, "R7 re-wake clears sleep bit",
          seq_data[base], WV);
    check(active && fsync_en && bclk_en, "R7 clocks on after re-wake", fsync_en, 1);
  endtask

  task automatic t_status_retry();
    int base = seq_n, gap;
    status_val = 8'h5F;                // bits[7:5]=010
    pulse_sleep();
    wait_idle();
    check(seq_n - base == 2 + RETRIES, "R6 status read count", seq_n - base, 2 + RETRIES);
    gap = seq_cyc[base+2] - seq_cyc[base+1];
    check(gap >= MS, "R6 re-read spacing", gap, MS);
    check(error && active && fsync_en, "R6 error with clocks running", error, 1);
    status_val = 8'h80;
    pulse_sleep();
    repeat (4) @(negedge clk);
    check(error == 0, "R6 error cleared at next sleep", error, 1'b0);
    wait_idle();
    check(!fsync_en && !active, "R6 later sleep completes", fsync_en, 0);
  endtask

  task automatic t_pending();
    int base = seq_n;
    pulse_wake();
    repeat (2) @(negedge clk);
    pulse_sleep();                     // arrives mid-wake
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3000 && (busy || active); i++) @(negedge clk);
    check(seq_n - base == 3, "R8 held sleep serviced after wake", seq_n - base, 3);
    check(seq_data[base+1] == SV && !fsync_en, "R8 ended asleep", fsync_en, 0);
  endtask

  task automatic t_supply_loss();
    int base;
    pulse_wake();
    wait_idle();
    check(active && fsync_en, "R10 active before supply loss", active, 1);
    @(negedge clk) supply_ok = 0;
    @(negedge clk);
    check(!fsync_en && !bclk_en && !active, "R10 clocks off after supply loss", fsync_en, 0);
    repeat (5) @(negedge clk);
    supply_ok = 1;
    wait_idle();
    base = seq_n;
    pulse_wake();
    wait_idle();
    check(seq_n - base == 10, "R10 full configuration after supply loss", seq_n - base, 10);
    check(viol == 0, "R11 command held until done", viol, 0);
  endtask

  initial begin
    status_val = 8'h80;
    t_reset();
    t_powerup_first_wake();
    t_same_mode_active();
    t_sleep_ok();
    t_same_mode_sleep();
    t_rewake();
    t_status_retry();
    t_pending();
    t_supply_loss();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule